// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block keeps the exception part of a 32-bit floating-point status register and updates it once for each completed arithmetic operation. The datapath presents a 5-bit vector of raw IEEE exception flags with a valid strobe. The block compares the flags with the trap-enable mask held in the register. It then rewrites the current-exception field, merges into or clears the accrued field, and writes a 3-bit trap-type code. When an enabled exception is raised, the block sends a registered one-cycle trap request to the trap logic.

When several enabled exceptions are raised at once, a fixed priority reduces them to one. An overflow or underflow that does not trap also raises inexact. Software loads the whole register through a plain write port, and that write wins over an update in the same cycle.

Top module: `fpx_status_rec`

## Requirements
- R1: After a cycle with `rst_n` low, `status_q` is all zeros and `trap_req` is low.
- R2: When `sw_wr_en` is high, the next `status_q` equals `sw_wr_data` in all 32 bits, whatever `op_valid` and `op_flags` are, and `trap_req` is low in the next cycle.
- R3: A cycle with `op_valid` low, or with `op_flags` equal to zero, leaves `status_q` unchanged and gives no trap request.
- R4: Flag order inside every field: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. The enable mask is `status_q[27:23]`. An update traps when `op_flags & mask` is nonzero. `trap_req` is then high for exactly the one cycle after the update edge.
- R5: On a trap, the flags are reduced to the enabled set. If more than one bit remains, only one is kept, in priority order invalid, then divide-by-zero, then inexact. If none of those three is present, the masked set is kept as is.
- R6: Every update overwrites the current field `status_q[4:0]` with the resulting flags, so no earlier bit survives there.
- R7: On an update that does not trap, if overflow or underflow is raised, inexact (bit 0) is also set in the current field.
- R8: The accrued field `status_q[9:5]` takes the OR of its old value and the raw `op_flags` on an update that does not trap. It is cleared to zero on a trap.
- R9: The trap-type field `status_q[16:14]` becomes 1 on a trap and 0 on an update that does not trap.
- R10: An update never changes the enable mask or any bit outside the current, accrued and trap-type fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation's flags are presented this cycle |
| op_flags | input | 5 | Raw exception flags of the operation |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Value loaded into the status register on a write |
| status_q | output | 32 | Status register contents |
| trap_req | output | 1 | One-cycle trap request, registered |

## Verification
The assertions assume that `op_flags` is only meaningful while `op_valid` is high, and that a software write overrides any update in the same cycle. Their properties are therefore written with `sw_wr_en` low as part of the antecedent. The stimulus draws random flags and strobes, and it issues frequent random software writes so that the enable mask covers many settings. Directed cases fix the mask to force multi-bit traps, untrapped overflow and underflow, a zero flag vector and a write colliding with an update.

// File: rtl/fpx_pkg.sv
// Package: shared field positions and flag encoding for the exception
// status recorder. Assumes the 5-bit flag order is the same in every field.
package fpx_pkg;
    localparam int FLAG_W   = 5;
    localparam int NV_BIT   = 4;   // invalid
    localparam int OF_BIT   = 3;   // overflow
    localparam int UF_BIT   = 2;   // underflow
    localparam int DZ_BIT   = 1;   // divide by zero
    localparam int NX_BIT   = 0;   // inexact
    localparam int CUR_LSB  = 0;
    localparam int ACC_LSB  = 5;
    localparam int TT_LSB   = 14;
    localparam int TT_W     = 3;
    localparam int MASK_LSB = 23;
    localparam int MIN_STAT_W = MASK_LSB + FLAG_W;
    localparam logic [TT_W-1:0] TT_IEEE = 3'd1;
    localparam logic [TT_W-1:0] TT_NONE = 3'd0;
    localparam int N_PRIO = 3;

    typedef logic [FLAG_W-1:0] flags_t;

    // Priority list used to reduce a multi-bit trapping set, highest first.
    function automatic int prio_bit(input int idx);
        case (idx)
            0:       return NV_BIT;
            1:       return DZ_BIT;
            default: return NX_BIT;
        endcase
    endfunction
endpackage

// File: rtl/fpx_trap_select.sv
// Module: decides whether the flags trap and picks the flags to record.
// Assumes raw_flags is already qualified by the caller; purely combinational.
module fpx_trap_select
    import fpx_pkg::*;
(
    input  flags_t raw_flags,
    input  flags_t en_mask,
    output logic   take_trap,
    output flags_t sel_flags
);
    flags_t masked;
    flags_t reduced;

    // Purpose: flags that are both raised and enabled.
    always_comb begin
        masked    = raw_flags & en_mask;
        take_trap = |masked;
    end

    // Purpose: keep one bit of a multi-bit trapping set by fixed priority.
    always_comb begin
        logic hit;
        reduced = masked;
        hit     = 1'b0;
        if ($countones(masked) > 1) begin
            for (int k = 0; k < N_PRIO; k++) begin
                if (!hit && masked[prio_bit(k)]) begin
                    reduced          = '0;
                    reduced[prio_bit(k)] = 1'b1;
                    hit              = 1'b1;
                end
            end
        end
    end

    // Purpose: recorded flags are the reduced set on a trap, raw otherwise.
    always_comb begin
        sel_flags = take_trap ? reduced : raw_flags;
    end
endmodule

// File: rtl/fpx_field_update.sv
// Module: builds the next status word from the current one and the
// selected flags. Assumes STAT_W covers the enable mask; combinational.
module fpx_field_update
    import fpx_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic [STAT_W-1:0] stat_cur,
    input  flags_t            raw_flags,
    input  flags_t            sel_flags,
    input  logic              take_trap,
    output logic [STAT_W-1:0] stat_nxt
);
    flags_t cur_field;
    flags_t acc_field;

    // Purpose: current field, with inexact added for untrapped OF/UF.
    always_comb begin
        cur_field = sel_flags;
        if (!take_trap && (sel_flags[OF_BIT] || sel_flags[UF_BIT]))
            cur_field[NX_BIT] = 1'b1;
    end

    // Purpose: accrued field merges raw flags, or clears on a trap.
    always_comb begin
        if (take_trap)
            acc_field = '0;
        else
            acc_field = stat_cur[ACC_LSB +: FLAG_W] | raw_flags;
    end

    // Purpose: assemble the word, leaving every other bit untouched.
    always_comb begin
        stat_nxt = stat_cur;
        stat_nxt[CUR_LSB +: FLAG_W] = cur_field;
        stat_nxt[ACC_LSB +: FLAG_W] = acc_field;
        stat_nxt[TT_LSB +: TT_W]    = take_trap ? TT_IEEE : TT_NONE;
    end
endmodule

// File: rtl/fpx_status_rec.sv
// Module: top of the exception status recorder. Holds the status register
// and the registered trap request. Assumes a software write has priority.
module fpx_status_rec
    import fpx_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_flags,
    input  logic              sw_wr_en,
    input  logic [STAT_W-1:0] sw_wr_data,
    output logic [STAT_W-1:0] status_q,
    output logic              trap_req
);
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] stat_nxt;
    logic              trap_q;
    logic              take_trap;
    flags_t            sel_flags;
    logic              upd_fire;

    // Purpose: an update needs a valid strobe and at least one flag.
    always_comb begin
        upd_fire = op_valid && (|op_flags);
    end

    fpx_trap_select u_sel (
        .raw_flags (op_flags),
        .en_mask   (stat_q[MASK_LSB +: FLAG_W]),
        .take_trap (take_trap),
        .sel_flags (sel_flags)
    );

    fpx_field_update #(.STAT_W(STAT_W)) u_upd (
        .stat_cur  (stat_q),
        .raw_flags (op_flags),
        .sel_flags (sel_flags),
        .take_trap (take_trap),
        .stat_nxt  (stat_nxt)
    );

    // Purpose: status register; software write wins over an update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else if (sw_wr_en)
            stat_q <= sw_wr_data;
        else if (upd_fire)
            stat_q <= stat_nxt;
    end

    // Purpose: one-cycle trap request for an update that trapped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trap_q <= 1'b0;
        else
            trap_q <= !sw_wr_en && upd_fire && take_trap;
    end

    assign status_q = stat_q;
    assign trap_req = trap_q;
endmodule

// File: rtl/fpx_status_rec_chk.sv
// Module: property checker bound to the status recorder top.
module fpx_status_rec_chk #(
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [4:0]        op_flags,
    input logic              sw_wr_en,
    input logic [STAT_W-1:0] sw_wr_data,
    input logic [STAT_W-1:0] status_q,
    input logic              trap_req
);
    p_sw_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (status_q == $past(sw_wr_data)) && !trap_req);

    p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && (!op_valid || op_flags == 5'd0)) |=> $stable(status_q) && !trap_req);

    p_trap_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req || $past(op_valid && !sw_wr_en));

    p_trap_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ((status_q[4:0] & status_q[27:23]) == status_q[4:0]) && (status_q[4:0] != 5'd0));

    p_acc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> status_q[9:5] == 5'd0);

    p_trap_type_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> status_q[16:14] == 3'd1);

    p_mask_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_en |=> $stable(status_q[31:17]) && $stable(status_q[13:10]));
endmodule

bind fpx_status_rec fpx_status_rec_chk #(.STAT_W(STAT_W)) u_chk (.*);

// File: tb/sim_fpx_status_rec.sv
module sim_fpx_status_rec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic [31:0] status_q;
    logic        trap_req;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] exp_stat = '0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    fpx_status_rec u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags(op_flags),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .status_q(status_q), .trap_req(trap_req)
    );

    // Expected {trap, status} after one edge, from the requirement text.
    function automatic logic [32:0] model(input logic [31:0] s, input logic v,
                                          input logic [4:0] f, input logic w,
                                          input logic [31:0] wd);
        logic [4:0] m, e, c;
        logic t;
        if (w) return {1'b0, wd};
        if (!v || f == 5'd0) return {1'b0, s};
        m = f & s[27:23];
        t = (m != 5'd0);
        e = t ? m : f;
        if (t && $countones(m) > 1) begin
            if (m[4])      e = 5'b10000;
            else if (m[1]) e = 5'b00010;
            else if (m[0]) e = 5'b00001;
        end
        c = e;
        if (!t && (e[3] || e[2])) c[0] = 1'b1;
        s[4:0]   = c;
        s[9:5]   = t ? 5'd0 : (s[9:5] | f);
        s[16:14] = t ? 3'd1 : 3'd0;
        return {t, s};
    endfunction

    task automatic step(input logic v, input logic [4:0] f, input logic w,
                        input logic [31:0] wd, input string tag);
        logic [32:0] r;
        @(negedge clk);
        op_valid = v; op_flags = f; sw_wr_en = w; sw_wr_data = wd;
        r = model(exp_stat, v, f, w, wd);
        @(posedge clk);
        @(negedge clk);
        exp_stat = r[31:0];
        n_vec++;
        if (status_q !== r[31:0] || trap_req !== r[32]) begin
            n_bad++;
            $display("FAIL %s: status=%h trap=%b expected status=%h trap=%b",
                     tag, status_q, trap_req, r[31:0], r[32]);
        end
        op_valid = 1'b0; op_flags = '0; sw_wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        n_vec++;
        if (status_q !== 32'd0 || trap_req !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: status=%h trap=%b expected status=0 trap=0", status_q, trap_req);
        end
        rst_n = 1'b1;
        // R3: idle and zero flags
        step(1'b0, 5'b11111, 1'b0, 32'd0, "R3 invalid strobe low");
        step(1'b1, 5'b00000, 1'b0, 32'd0, "R3 zero flags");
        // R7: untrapped overflow then underflow force inexact
        step(1'b1, 5'b01000, 1'b0, 32'd0, "R7 overflow untrapped");
        step(1'b1, 5'b00100, 1'b0, 32'd0, "R7 underflow untrapped");
        // R6: current field overwritten, R8 accrued merged
        step(1'b1, 5'b00010, 1'b0, 32'd0, "R6 current overwritten");
        step(1'b1, 5'b10000, 1'b0, 32'd0, "R8 accrued merge");
        // R2: write with colliding update; enable all, upper bits set
        step(1'b1, 5'b11111, 1'b1, 32'hFF80_03E0 | 32'hF000_0000, "R2 write wins");
        // R5: multi-bit trap reductions
        step(1'b1, 5'b11011, 1'b0, 32'd0, "R5 invalid first");
        step(1'b0, 5'b00000, 1'b0, 32'd0, "R4 trap pulse ends");
        step(1'b1, 5'b01011, 1'b0, 32'd0, "R5 divzero next");
        step(1'b1, 5'b01101, 1'b0, 32'd0, "R5 inexact last");
        step(1'b1, 5'b01100, 1'b0, 32'd0, "R5 of+uf kept");
        // R4/R9: mask only overflow; underflow alone does not trap
        step(1'b0, 5'b00000, 1'b1, 32'h0440_0000, "R2 mask load");
        step(1'b1, 5'b00100, 1'b0, 32'd0, "R9 untrapped clears type");
        step(1'b1, 5'b01100, 1'b0, 32'd0, "R4 overflow traps");
        step(1'b1, 5'b00001, 1'b0, 32'd0, "R8 accrued after trap");
        step(1'b1, 5'b01000, 1'b0, 32'd0, "R10 mask kept");
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic w;
            w = ($urandom_range(0, 7) == 0);
            step($urandom_range(0, 3) != 0, 5'($urandom), w, $urandom, "random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule